// File: doc/BRIEF.md
# Single-Bus Accumulator Datapath

This block is the datapath of a small stored-program computer in which every transfer travels over one shared 8-bit bus. It holds a 4-bit program counter, a 4-bit memory address register, a 16-entry by 8-bit RAM, an 8-bit instruction register, an accumulator, an operand register and an add/subtract unit. An external sequencer presents a 16-bit control word each cycle. The control word selects at most one bus source, and every register whose load bit is set takes the bus value on the next rising edge.

The instruction register's upper nibble is exported as the opcode so that the sequencer can decode it. The bus value is visible at all times. A display capture bit latches the bus into an output register and raises a one-cycle strobe. A preload port writes RAM directly so that a program and its data can be placed before execution. A halt bit in the control word is passed straight to an output for the clock controller.

Top module: `acc_bus_datapath`

## Requirements
- R1: Control word bits: 0 PC-to-bus, 1 MAR load, 2 RAM-to-bus, 3 RAM write, 4 IR load, 5 IR-operand-to-bus, 6 A load, 7 A-to-bus, 8 B load, 9 B-to-bus, 10 ALU-to-bus, 11 subtract, 12 PC increment, 13 PC load, 14 display capture, 15 halt. In a cycle with exactly one source bit set, the bus shows that source. With no source bit set, the bus reads 0x00.
- R2: The PC and the IR operand (IR bits [3:0]) occupy bus bits [3:0], and bus bits [7:4] read zero while either of them drives the bus.
- R3: On a rising edge the PC loads bus[3:0] when bit 13 is set, whether or not bit 12 is set. It increments modulo 16 when only bit 12 is set, and it holds when neither bit is set.
- R4: The ALU output is combinational. It is (A+B) mod 256 when bit 11 is 0 and (A+~B+1) mod 256 when bit 11 is 1.
- R5: A RAM read returns the word at the current MAR address in the same cycle. A RAM write stores the bus value at the MAR address on the rising edge. A preload write on the same edge takes priority over a bus write.
- R6: A, B, MAR and IR load the bus value on the rising edge when their load bit is set, and hold otherwise. The opcode output equals IR bits [7:4].
- R7: With bit 14 set, the display value takes the bus value on the rising edge and the display strobe is high for the following cycle only. Otherwise the display value holds.
- R8: After reset, PC, MAR, IR, A, B and the display value are 0x00, and the strobe is low.
- R9: Running the program 1E 2F E0 F0 with RAM[E]=05 and RAM[F]=03 leaves A=08, B=03, PC=4 and display value 08.
- R10: The halt output follows control bit 15 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl | input | 16 | Control word for this cycle |
| pre_we | input | 1 | Preload write enable |
| pre_addr | input | 4 | Preload RAM address |
| pre_data | input | 8 | Preload RAM data |
| opcode | output | 4 | IR upper nibble |
| bus_val | output | 8 | Current bus value |
| disp_stb | output | 1 | High for one cycle after a display capture |
| disp_val | output | 8 | Captured display value |
| halt_req | output | 1 | Halt bit of the control word |

## Verification
The bus value and the halt output depend only on the current control word and the register state, so the bench applies each control word at the falling edge and samples a quarter period later, inside the same cycle. Register, PC, RAM-write and display results take effect at the next rising edge. The bench therefore observes them one step later, by selecting the register as the bus source or reading the display pins. The display strobe is checked in the cycle after the capture and again one cycle later, where it must be low.

// File: rtl/acc_bus_datapath.sv
module acc_bus_datapath #(
  parameter int DW = 8,
  parameter int AW = 4,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] ctrl,
  input  logic          pre_we,
  input  logic [AW-1:0] pre_addr,
  input  logic [DW-1:0] pre_data,
  output logic [DW-AW-1:0] opcode,
  output logic [DW-1:0] bus_val,
  output logic          disp_stb,
  output logic [DW-1:0] disp_val,
  output logic          halt_req
);
  localparam int DEPTH = 1 << AW;
  localparam int XW    = DW - AW;

  logic pc_oe, mar_ld, ram_oe, ram_we, ir_ld, ir_oe, a_ld, a_oe;
  logic b_ld, b_oe, alu_oe, sub, pc_inc, pc_ld, disp_ld;

  assign pc_oe   = ctrl[0];
  assign mar_ld  = ctrl[1];
  assign ram_oe  = ctrl[2];
  assign ram_we  = ctrl[3];
  assign ir_ld   = ctrl[4];
  assign ir_oe   = ctrl[5];
  assign a_ld    = ctrl[6];
  assign a_oe    = ctrl[7];
  assign b_ld    = ctrl[8];
  assign b_oe    = ctrl[9];
  assign alu_oe  = ctrl[10];
  assign sub     = ctrl[11];
  assign pc_inc  = ctrl[12];
  assign pc_ld   = ctrl[13];
  assign disp_ld = ctrl[14];
  assign halt_req = ctrl[15];

  logic [AW-1:0] pc_q, mar_q;
  logic [DW-1:0] ir_q, a_q, b_q;
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_data, alu_y, bus;

  assign rd_data = mem[mar_q];
  assign alu_y   = a_q + (b_q ^ {DW{sub}}) + {{(DW-1){1'b0}}, sub};

  assign bus = ({DW{pc_oe}}  & {{XW{1'b0}}, pc_q})
             | ({DW{ram_oe}} & rd_data)
             | ({DW{ir_oe}}  & {{XW{1'b0}}, ir_q[AW-1:0]})
             | ({DW{a_oe}}   & a_q)
             | ({DW{b_oe}}   & b_q)
             | ({DW{alu_oe}} & alu_y);

  assign bus_val = bus;
  assign opcode  = ir_q[DW-1:AW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else if (pc_ld) begin
      pc_q <= bus[AW-1:0];
    end else if (pc_inc) begin
      pc_q <= pc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mar_q <= '0;
      ir_q  <= '0;
      a_q   <= '0;
      b_q   <= '0;
    end else begin
      if (mar_ld) mar_q <= bus[AW-1:0];
      if (ir_ld)  ir_q  <= bus;
      if (a_ld)   a_q   <= bus;
      if (b_ld)   b_q   <= bus;
    end
  end

  always_ff @(posedge clk) begin
    if (pre_we)      mem[pre_addr] <= pre_data;
    else if (ram_we) mem[mar_q]    <= bus;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp_val <= '0;
      disp_stb <= 1'b0;
    end else begin
      disp_stb <= disp_ld;
      if (disp_ld) disp_val <= bus;
    end
  end
endmodule

// File: rtl/acc_bus_datapath_chk.sv
module acc_bus_datapath_chk #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [15:0]   ctrl,
  input logic [DW-1:0] bus,
  input logic [AW-1:0] pc,
  input logic [DW-1:0] acc,
  input logic [DW-1:0] opr,
  input logic [DW-1:0] dval,
  input logic          dstb
);
  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrl[0], ctrl[2], ctrl[5], ctrl[7], ctrl[9], ctrl[10]})); // R1
  AST_ZERO_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[0] || ctrl[5]) |-> bus[DW-1:AW] == '0); // R2
  AST_PC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[13] |=> pc == $past(bus[AW-1:0])); // R3
  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[12] && !ctrl[13]) |=> pc == $past(pc) + 1'b1); // R3
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[12] && !ctrl[13]) |=> $stable(pc)); // R3
  AST_RAM_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl[2] && ctrl[3])); // R5
  AST_A_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[6] |=> acc == $past(bus)); // R6
  AST_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[8] |=> $stable(opr)); // R6
  AST_DISP_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[14] |=> (dstb && dval == $past(bus))); // R7
  AST_DISP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[14] |=> (!dstb && $stable(dval))); // R7
endmodule

bind acc_bus_datapath acc_bus_datapath_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl(ctrl[15:0]), .bus(bus_val), .pc(pc_q),
  .acc(a_q), .opr(b_q), .dval(disp_val), .dstb(disp_stb)
);

// File: tb/acc_bus_datapath_tb_top.sv
module acc_bus_datapath_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] ctrl = '0;
  logic pre_we = 1'b0;
  logic [3:0] pre_addr = '0;
  logic [7:0] pre_data = '0;
  logic [3:0] opcode;
  logic [7:0] bus_val, disp_val;
  logic disp_stb, halt_req;

  always #10 clk = ~clk;

  acc_bus_datapath dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .pre_we(pre_we),
    .pre_addr(pre_addr), .pre_data(pre_data), .opcode(opcode),
    .bus_val(bus_val), .disp_stb(disp_stb), .disp_val(disp_val),
    .halt_req(halt_req)
  );

  localparam logic [15:0] PC_OUT = 16'h0001, MAR_IN = 16'h0002, RAM_OUT = 16'h0004;
  localparam logic [15:0] RAM_IN = 16'h0008, IR_IN = 16'h0010, IR_OUT = 16'h0020;
  localparam logic [15:0] A_IN = 16'h0040, A_OUT = 16'h0080, B_IN = 16'h0100;
  localparam logic [15:0] B_OUT = 16'h0200, ALU_OUT = 16'h0400, SUB = 16'h0800;
  localparam logic [15:0] PC_INC = 16'h1000, PC_LD = 16'h2000, DISP = 16'h4000;
  localparam logic [15:0] HALT = 16'h8000;

  localparam int NV = 18;
  localparam logic [23:0] TRACE [NV] = '{
    {16'h0003, 8'h00}, {16'h1014, 8'h1E}, {16'h0022, 8'h0E}, {16'h0044, 8'h05},
    {16'h0003, 8'h01}, {16'h1014, 8'h2F}, {16'h0022, 8'h0F}, {16'h0104, 8'h03},
    {16'h0440, 8'h08},
    {16'h0003, 8'h02}, {16'h1014, 8'hE0}, {16'h4080, 8'h08},
    {16'h0003, 8'h03}, {16'h1014, 8'hF0}, {16'h8000, 8'h00},
    {16'h0080, 8'h08}, {16'h0200, 8'h03}, {16'h0001, 8'h04}
  };

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [7:0] s_bus, s_disp;
  logic [3:0] s_op;
  logic s_stb, s_halt;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [15:0] w);
    @(negedge clk);
    ctrl = w;
    #5;
    s_bus = bus_val; s_disp = disp_val; s_op = opcode;
    s_stb = disp_stb; s_halt = halt_req;
    @(posedge clk);
  endtask

  task automatic preload(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    ctrl = '0; pre_we = 1'b1; pre_addr = a; pre_data = d;
    @(posedge clk);
    #1 pre_we = 1'b0;
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R8 reset state, R1 idle bus
    step(16'h0000);
    chk("R8 disp_val", s_disp, 8'h00);
    chk("R8 disp_stb", {7'b0, s_stb}, 8'h00);
    chk("R8 opcode", {4'b0, s_op}, 8'h00);
    chk("R1 idle bus", s_bus, 8'h00);
    step(PC_OUT);  chk("R8 pc", s_bus, 8'h00);
    step(A_OUT);   chk("R8 A", s_bus, 8'h00);
    step(B_OUT);   chk("R8 B", s_bus, 8'h00);
    step(IR_OUT);  chk("R8 IR", s_bus, 8'h00);

    // R9 program run
    preload(4'h0, 8'h1E); preload(4'h1, 8'h2F);
    preload(4'h2, 8'hE0); preload(4'h3, 8'hF0);
    preload(4'hE, 8'h05); preload(4'hF, 8'h03);
    for (int i = 0; i < NV; i++) begin
      step(TRACE[i][23:8]);
      chk($sformatf("R9 trace step %0d", i), s_bus, TRACE[i][7:0]);
    end
    chk("R9 display", s_disp, 8'h08);
    chk("R6 opcode after HLT fetch", {4'b0, s_op}, 8'h0F);

    // R10 halt output
    step(HALT);    chk("R10 halt high", {7'b0, s_halt}, 8'h01);
    step(16'h0000); chk("R10 halt low", {7'b0, s_halt}, 8'h00);

    // R2 immediate zero-extension, R6 loads (MAR is 3)
    preload(4'h3, 8'h59);
    step(RAM_OUT | IR_IN);
    step(16'h0000); chk("R6 opcode", {4'b0, s_op}, 8'h05);
    step(IR_OUT | A_IN); chk("R2 operand zero-extended", s_bus, 8'h09);
    step(A_OUT); chk("R6 A loaded", s_bus, 8'h09);
    chk("R7 display holds", s_disp, 8'h08);
    chk("R7 strobe idle", {7'b0, s_stb}, 8'h00);

    // R7 capture and one-cycle strobe
    step(A_OUT | DISP);
    step(16'h0000);
    chk("R7 captured", s_disp, 8'h09);
    chk("R7 strobe high", {7'b0, s_stb}, 8'h01);
    step(16'h0000);
    chk("R7 strobe low", {7'b0, s_stb}, 8'h00);
    chk("R7 hold", s_disp, 8'h09);

    // R3 PC priority, increment, hold, wrap
    step(IR_OUT | PC_INC | PC_LD);
    step(PC_OUT); chk("R3 load beats increment", s_bus, 8'h09);
    step(PC_INC);
    step(16'h0000);
    step(PC_OUT); chk("R3 increment then hold", s_bus, 8'h0A);
    preload(4'h3, 8'h6F);
    step(RAM_OUT | IR_IN);
    step(IR_OUT | PC_LD); chk("R2 operand F", s_bus, 8'h0F);
    step(PC_INC);
    step(PC_OUT); chk("R3 wrap to 0", s_bus, 8'h00);

    // R4 ALU add/sub wrap
    step(IR_OUT | MAR_IN);
    preload(4'hF, 8'hFF); step(RAM_OUT | A_IN);
    preload(4'hF, 8'h01); step(RAM_OUT | B_IN);
    step(ALU_OUT);       chk("R4 FF+01", s_bus, 8'h00);
    step(ALU_OUT | SUB); chk("R4 FF-01", s_bus, 8'hFE);
    step(ALU_OUT | A_IN);
    step(ALU_OUT | SUB); chk("R4 00-01", s_bus, 8'hFF);
    preload(4'hF, 8'h08); step(RAM_OUT | A_IN);
    preload(4'hF, 8'h03); step(RAM_OUT | B_IN);
    step(ALU_OUT | SUB); chk("R4 08-03", s_bus, 8'h05);
    step(ALU_OUT);       chk("R4 08+03", s_bus, 8'h0B);

    // R5 RAM write, same-cycle read, preload priority
    step(A_OUT | RAM_IN);
    step(RAM_OUT); chk("R5 bus write", s_bus, 8'h08);
    preload(4'hF, 8'h13);
    step(RAM_OUT | IR_IN);
    step(IR_OUT | MAR_IN);
    preload(4'h3, 8'hC3);
    step(RAM_OUT); chk("R5 read at new MAR", s_bus, 8'hC3);
    @(negedge clk);
    ctrl = A_OUT | RAM_IN; pre_we = 1'b1; pre_addr = 4'h3; pre_data = 8'h77;
    @(posedge clk);
    #1 pre_we = 1'b0;
    step(RAM_OUT); chk("R5 preload wins", s_bus, 8'h77);
    step(B_OUT); chk("R6 B holds", s_bus, 8'h03);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule